// File: doc/BRIEF.md
# Interrupt Coalescing Delay Unit

This block sits between the per-packet completion pulses of a receive path and a transmit path and the single interrupt line a processor sees. The goal is to raise one interrupt per batch rather than one per packet. Each direction keeps a count of completions that are still waiting and a timer that measures how long the oldest of them has waited. A delayed interrupt flag for that direction is raised as soon as either the count reaches its configured limit or the wait reaches its configured time limit. The time limit is expressed in units of 20 µs, and those units are derived from the system clock by a prescaler whose divisor is a parameter.

Software sets the two limits for each direction through a small register port. It reads and clears the status flags through the same port, and it chooses which flags drive the interrupt output. Each receive queue also has its own completion flag. The status flags are cleared by writing ones. A time limit of zero switches coalescing off for that direction.

Top module: `irq_coalesce_top`

## Requirements
- R1: With a nonzero count limit, a direction's delayed flag is set on the clock edge after the edge at which its pending count reaches or exceeds that limit. Receive completions from several queues in one cycle all add to the receive count.
- R2: When only the time limit applies, the first completion is captured at edge E and the delayed flag is set at edge E + time_limit*CLK_DIV + 1.
- R3: A time limit of zero disables the direction. No delayed flag is raised, and the pending count and timer are cleared, so re-enabling later does not fire on old events.
- R4: A count limit of zero leaves only the time trigger active, however many completions pile up.
- R5: The wait timer starts with the first completion after the pending state is empty. Idle time before that completion does not count toward the limit.
- R6: When a delayed interrupt fires, the count and the timer restart from zero on that edge. A completion captured on that same edge counts as the first of the next batch.
- R7: Status bit 30 is the receive delayed flag and bit 28 is the transmit delayed flag. Bit 16+q is the done flag of receive queue q, and it is set on the edge after a pulse on that queue.
- R8: Writing the status register clears every bit written as 1 and leaves bits written as 0 unchanged. A flag set on the same edge as its clear stays set.
- R9: irq is high exactly when some status bit and the same bit of the enable mask register are both 1. The mask holds only the defined status bit positions.
- R10: After reset, all status, mask and configuration registers read 0 and irq is 0.
- R11: The register map is as follows. Address 0 is the receive limits, with the time limit in bits 7:0 and the count limit in bits 15:8. Address 1 is the transmit limits in the same layout. Address 2 is status and address 3 is the mask. Other addresses and unused bits read 0. rd_data follows rd_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | NUM_RXQ | One-cycle completion pulse per receive queue |
| tx_done | input | 1 | One-cycle transmit completion pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Register read data |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that completion inputs are single-cycle pulses sampled at rising edges. They also assume that configuration may change at any cycle, so the disable and restart properties are written one edge after the configuration or fire condition they depend on. The stimulus changes inputs just after a rising edge and holds them for exactly one cycle. It reconfigures a direction only between batches, except in the deliberate case where a pending batch is cut off by disabling it. Clear writes are placed both apart from and on top of flag-setting edges, which exercises the collision rule.

// File: rtl/coal_pkg.sv
package coal_pkg;
   localparam int REG_W      = 32;
   localparam int ADDR_RXCFG = 0;
   localparam int ADDR_TXCFG = 1;
   localparam int ADDR_STS   = 2;
   localparam int ADDR_MASK  = 3;
   localparam int BIT_RX_DLY = 30;
   localparam int BIT_TX_DLY = 28;
   localparam int BIT_RXQ0   = 16;
   localparam int MAX_RXQ    = 8;

   function automatic logic [REG_W-1:0] sts_valid(int nq);
      logic [REG_W-1:0] v;
      v = '0;
      v[BIT_RX_DLY] = 1'b1;
      v[BIT_TX_DLY] = 1'b1;
      for (int q = 0; q < nq; q++) v[BIT_RXQ0+q] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/coal_popcnt.sv
module coal_popcnt #(
   parameter int N  = 2,
   parameter int OW = 2
) (
   input  logic [N-1:0]  bits,
   output logic [OW-1:0] total
);
   generate
      if (N < 1) begin : g_bad_n
         $error("coal_popcnt: N must be at least 1");
      end
      if (N == 1) begin : g_single
         assign total = OW'(bits);
      end else begin : g_sum
         always_comb begin
            total = '0;
            for (int i = 0; i < N; i++) total = total + OW'(bits[i]);
         end
      end
   endgenerate
endmodule

// File: rtl/coal_chan.sv
module coal_chan #(
   parameter int CNT_W   = 8,
   parameter int TIME_W  = 8,
   parameter int EV_W    = 2,
   parameter int CLK_DIV = 2500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EV_W-1:0]   ev_num,
   input  logic [CNT_W-1:0]  max_cnt,
   input  logic [TIME_W-1:0] max_time,
   output logic              fire
);
   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

   generate
      if (CLK_DIV < 2) begin : g_bad_div
         $error("coal_chan: CLK_DIV must be at least 2");
      end
      if (EV_W > CNT_W) begin : g_bad_ev
         $error("coal_chan: EV_W must not exceed CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [TIME_W-1:0] tmr_q;
   logic [DIV_W-1:0]  div_q;
   logic [CNT_W:0]    cnt_wide;
   logic [CNT_W-1:0]  cnt_sum;
   logic              enabled, pending, cnt_hit, time_hit, tick;

   always_comb begin
      enabled  = (max_time != '0);
      pending  = (cnt_q != '0);
      cnt_hit  = (max_cnt != '0) && (cnt_q >= max_cnt);
      time_hit = (tmr_q >= max_time);
      fire     = enabled && pending && (cnt_hit || time_hit);
      tick     = pending && (div_q == DIV_LAST);
      cnt_wide = {1'b0, cnt_q} + (CNT_W+1)'(ev_num);
      cnt_sum  = cnt_wide[CNT_W] ? '1 : cnt_wide[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tmr_q <= '0;
         div_q <= '0;
      end else if (!enabled) begin
         cnt_q <= '0;
         tmr_q <= '0;
         div_q <= '0;
      end else if (fire) begin
         cnt_q <= CNT_W'(ev_num);
         tmr_q <= '0;
         div_q <= '0;
      end else begin
         cnt_q <= cnt_sum;
         if (pending) begin
            if (tick) begin
               div_q <= '0;
               if (tmr_q != '1) tmr_q <= tmr_q + 1'b1;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/coal_regs.sv
module coal_regs
   import coal_pkg::*;
#(
   parameter int NUM_RXQ = 2,
   parameter int ADDR_W  = 3,
   parameter int CNT_W   = 8,
   parameter int TIME_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [REG_W-1:0]  set_vec,
   output logic [REG_W-1:0]  rd_data,
   output logic [TIME_W-1:0] rx_time,
   output logic [CNT_W-1:0]  rx_cnt,
   output logic [TIME_W-1:0] tx_time,
   output logic [CNT_W-1:0]  tx_cnt,
   output logic [REG_W-1:0]  sts,
   output logic              irq
);
   localparam int CFG_W = CNT_W + TIME_W;
   localparam logic [REG_W-1:0] VALID = sts_valid(NUM_RXQ);

   logic [CFG_W-1:0] rx_cfg_q, tx_cfg_q;
   logic [REG_W-1:0] sts_q, mask_q, clr_vec;
   logic             hit_rx, hit_tx, hit_sts, hit_mask;

   always_comb begin
      hit_rx   = wr_en && (wr_addr == ADDR_W'(ADDR_RXCFG));
      hit_tx   = wr_en && (wr_addr == ADDR_W'(ADDR_TXCFG));
      hit_sts  = wr_en && (wr_addr == ADDR_W'(ADDR_STS));
      hit_mask = wr_en && (wr_addr == ADDR_W'(ADDR_MASK));
      clr_vec  = hit_sts ? wr_data : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_cfg_q <= '0;
         tx_cfg_q <= '0;
         sts_q    <= '0;
         mask_q   <= '0;
      end else begin
         if (hit_rx)   rx_cfg_q <= wr_data[CFG_W-1:0];
         if (hit_tx)   tx_cfg_q <= wr_data[CFG_W-1:0];
         if (hit_mask) mask_q   <= wr_data & VALID;
         sts_q <= ((sts_q & ~clr_vec) | set_vec) & VALID;
      end
   end

   always_comb begin
      unique case (rd_addr)
         ADDR_W'(ADDR_RXCFG): rd_data = REG_W'(rx_cfg_q);
         ADDR_W'(ADDR_TXCFG): rd_data = REG_W'(tx_cfg_q);
         ADDR_W'(ADDR_STS):   rd_data = sts_q;
         ADDR_W'(ADDR_MASK):  rd_data = mask_q;
         default:             rd_data = '0;
      endcase
   end

   assign rx_time = rx_cfg_q[TIME_W-1:0];
   assign rx_cnt  = rx_cfg_q[TIME_W +: CNT_W];
   assign tx_time = tx_cfg_q[TIME_W-1:0];
   assign tx_cnt  = tx_cfg_q[TIME_W +: CNT_W];
   assign sts     = sts_q;
   assign irq     = |(sts_q & mask_q);
endmodule

// File: rtl/irq_coalesce_top.sv
module irq_coalesce_top
   import coal_pkg::*;
#(
   parameter int NUM_RXQ = 2,
   parameter int CNT_W   = 8,
   parameter int TIME_W  = 8,
   parameter int ADDR_W  = 3,
   parameter int CLK_DIV = 2500
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_RXQ-1:0] rx_done,
   input  logic               tx_done,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [REG_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [REG_W-1:0]   rd_data,
   output logic               irq
);
   localparam int EV_RX_W = $clog2(NUM_RXQ + 1);

   generate
      if (NUM_RXQ < 1 || NUM_RXQ > MAX_RXQ) begin : g_bad_q
         $error("irq_coalesce_top: NUM_RXQ out of range");
      end
      if (CNT_W + TIME_W > REG_W) begin : g_bad_cfg
         $error("irq_coalesce_top: limit fields exceed register width");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("irq_coalesce_top: ADDR_W too small for the map");
      end
   endgenerate

   logic [EV_RX_W-1:0] rx_ev;
   logic [TIME_W-1:0]  rx_time, tx_time;
   logic [CNT_W-1:0]   rx_cnt, tx_cnt;
   logic               rx_fire, tx_fire;
   logic [REG_W-1:0]   set_vec, sts_w;

   coal_popcnt #(.N(NUM_RXQ), .OW(EV_RX_W)) u_rx_pop (
      .bits  (rx_done),
      .total (rx_ev)
   );

   coal_chan #(.CNT_W(CNT_W), .TIME_W(TIME_W), .EV_W(EV_RX_W), .CLK_DIV(CLK_DIV)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_num   (rx_ev),
      .max_cnt  (rx_cnt),
      .max_time (rx_time),
      .fire     (rx_fire)
   );

   coal_chan #(.CNT_W(CNT_W), .TIME_W(TIME_W), .EV_W(1), .CLK_DIV(CLK_DIV)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_num   (tx_done),
      .max_cnt  (tx_cnt),
      .max_time (tx_time),
      .fire     (tx_fire)
   );

   always_comb begin
      set_vec = '0;
      set_vec[BIT_RX_DLY] = rx_fire;
      set_vec[BIT_TX_DLY] = tx_fire;
   end

   generate
      for (genvar q = 0; q < NUM_RXQ; q++) begin : g_qset
         logic unused_q;
         assign unused_q = 1'b0;
      end
   endgenerate

   logic [REG_W-1:0] set_all;
   always_comb begin
      set_all = set_vec;
      set_all[BIT_RXQ0 +: NUM_RXQ] = rx_done;
   end

   coal_regs #(.NUM_RXQ(NUM_RXQ), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .set_vec (set_all),
      .rd_data (rd_data),
      .rx_time (rx_time),
      .rx_cnt  (rx_cnt),
      .tx_time (tx_time),
      .tx_cnt  (tx_cnt),
      .sts     (sts_w),
      .irq     (irq)
   );
endmodule

// File: rtl/coal_chk.sv
module coal_chk
   import coal_pkg::*;
#(
   parameter int NUM_RXQ = 2,
   parameter int CNT_W   = 8,
   parameter int TIME_W  = 8,
   parameter int ADDR_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              q0_done,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_d28,
   input logic              sts_rx,
   input logic              sts_tx,
   input logic              sts_q0,
   input logic              rx_fire,
   input logic              tx_fire,
   input logic [TIME_W-1:0] rx_tcfg,
   input logic [CNT_W-1:0]  rx_pend,
   input logic [TIME_W-1:0] rx_tmr
);
   AST_RX_FIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fire |=> sts_rx);                                                  // R7
   AST_TX_FIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fire |=> sts_tx);                                                  // R7
   AST_QUEUE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      q0_done |=> sts_q0);                                                  // R7
   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_tcfg == '0) |=> (rx_pend == '0));                                 // R3
   AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pend == '0) |-> (rx_tmr == '0));                                  // R5
   AST_FIRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fire |=> ((rx_tmr == '0) && (rx_pend <= CNT_W'(NUM_RXQ))));        // R6
   AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADDR_W'(ADDR_STS)) && wr_d28 && !tx_fire) |=> !sts_tx); // R8
endmodule

bind irq_coalesce_top coal_chk #(
   .NUM_RXQ(NUM_RXQ), .CNT_W(CNT_W), .TIME_W(TIME_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .q0_done (rx_done[0]),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_d28  (wr_data[28]),
   .sts_rx  (sts_w[30]),
   .sts_tx  (sts_w[28]),
   .sts_q0  (sts_w[16]),
   .rx_fire (rx_fire),
   .tx_fire (tx_fire),
   .rx_tcfg (rx_time),
   .rx_pend (u_rx.cnt_q),
   .rx_tmr  (u_rx.tmr_q)
);

// File: tb/tb_irq_coalesce_top.sv
`timescale 1ns/1ps
module tb_irq_coalesce_top;
   localparam int NQ  = 2;
   localparam int DIV = 4;
   localparam logic [31:0] VALID = (32'd1 << 30) | (32'd1 << 28) | (((32'd1 << NQ) - 1) << 16);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NQ-1:0] rx_done = '0;
   logic          tx_done = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [2:0]    rd_addr = 3'd2;
   logic [31:0]   rd_data;
   logic          irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   irq_coalesce_top #(.NUM_RXQ(NQ), .CNT_W(8), .TIME_W(8), .ADDR_W(3), .CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .tx_done(tx_done),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   // behavioural reference model
   int          m_rc, m_re, m_tc, m_te;
   int          m_rmt, m_rmc, m_tmt, m_tmc;
   logic [31:0] m_st, m_mask;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rc = 0; m_re = 0; m_tc = 0; m_te = 0;
         m_rmt = 0; m_rmc = 0; m_tmt = 0; m_tmc = 0;
         m_st = '0; m_mask = '0;
      end else begin
         bit fr, ft;
         int pc;
         logic [31:0] clr, setv;
         pc = $countones(rx_done);
         fr = (m_rmt != 0) && (m_rc > 0) && (((m_rmc != 0) && (m_rc >= m_rmc)) || (m_re >= m_rmt * DIV));
         ft = (m_tmt != 0) && (m_tc > 0) && (((m_tmc != 0) && (m_tc >= m_tmc)) || (m_te >= m_tmt * DIV));
         clr  = (wr_en && wr_addr == 3'd2) ? wr_data : 32'd0;
         setv = (32'(fr) << 30) | (32'(ft) << 28) | (32'(rx_done) << 16);
         m_st = ((m_st & ~clr) | setv) & VALID;
         if (m_rmt == 0) begin m_rc = 0; m_re = 0; end
         else if (fr) begin m_rc = pc; m_re = 0; end
         else begin
            if (m_rc > 0) m_re++;
            m_rc = (m_rc + pc > 255) ? 255 : m_rc + pc;
         end
         if (m_tmt == 0) begin m_tc = 0; m_te = 0; end
         else if (ft) begin m_tc = int'(tx_done); m_te = 0; end
         else begin
            if (m_tc > 0) m_te++;
            m_tc = (m_tc + int'(tx_done) > 255) ? 255 : m_tc + int'(tx_done);
         end
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin m_rmt = int'(wr_data[7:0]); m_rmc = int'(wr_data[15:8]); end
               3'd1: begin m_tmt = int'(wr_data[7:0]); m_tmc = int'(wr_data[15:8]); end
               3'd3: m_mask = wr_data & VALID;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         logic [31:0] e;
         case (rd_addr)
            3'd0: e = 32'((m_rmc << 8) | m_rmt);
            3'd1: e = 32'((m_tmc << 8) | m_tmt);
            3'd2: e = m_st;
            3'd3: e = m_mask;
            default: e = '0;
         endcase
         chk("R11 rd_data vs model", rd_data, e);
         chk("R9 irq vs model", 32'(irq), 32'(|(m_st & m_mask)));
      end
   end

   task automatic cyc(input logic [NQ-1:0] rx, input logic tx, input logic we,
                      input logic [2:0] wa, input logic [31:0] wd);
      @(posedge clk);
      #1;
      rx_done = rx; tx_done = tx; wr_en = we; wr_addr = wa; wr_data = wd;
   endtask

   task automatic idle(); cyc('0, 1'b0, 1'b0, 3'd0, 32'd0); endtask
   task automatic wr(input logic [2:0] a, input logic [31:0] d); cyc('0, 1'b0, 1'b1, a, d); endtask

   task automatic wait_flag(input int b, input int lim, output int n);
      n = 0;
      while (n < lim) begin
         idle();
         n++;
         if (rd_data[b]) break;
      end
   endtask

   task automatic peek(input logic [2:0] a);
      rd_addr = a;
      #1;
   endtask

   initial begin
      int n;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      chk("R10 status after reset", rd_data, 32'd0);
      chk("R10 irq after reset", 32'(irq), 32'd0);
      peek(3'd0); chk("R10 rx limits after reset", rd_data, 32'd0);
      peek(3'd3); chk("R10 mask after reset", rd_data, 32'd0);
      peek(3'd2);

      // R1: tx count trigger
      wr(3'd1, (32'd3 << 8) | 32'd50);
      repeat (3) cyc('0, 1'b1, 1'b0, 3'd0, 32'd0);
      wait_flag(28, 20, n);
      chk("R1 tx count trigger latency", 32'(n), 32'd2);
      chk("R7 rx delayed flag stays clear", 32'(rd_data[30]), 32'd0);
      wr(3'd2, 32'hFFFF_FFFF);

      // R1: two rx queues in one cycle reach a count of 2
      wr(3'd0, (32'd2 << 8) | 32'd50);
      cyc(2'b11, 1'b0, 1'b0, 3'd0, 32'd0);
      idle();
      chk("R7 queue done flags bits 17:16", 32'(rd_data[17:16]), 32'd3);
      chk("R1 no rx flag before count edge", 32'(rd_data[30]), 32'd0);
      idle();
      chk("R1 rx flag after two-queue count", 32'(rd_data[30]), 32'd1);
      wr(3'd2, 32'hFFFF_FFFF);

      // R2: time trigger only
      wr(3'd0, 32'd3);
      cyc(2'b01, 1'b0, 1'b0, 3'd0, 32'd0);
      wait_flag(30, 40, n);
      chk("R2 time trigger latency", 32'(n), 32'(3 * DIV + 2));
      wr(3'd2, 32'hFFFF_FFFF);

      // R5: long idle before the first event does not count
      repeat (40) idle();
      cyc(2'b10, 1'b0, 1'b0, 3'd0, 32'd0);
      wait_flag(30, 40, n);
      chk("R5 timer starts at first event", 32'(n), 32'(3 * DIV + 2));
      wr(3'd2, 32'hFFFF_FFFF);

      // R4: zero count limit, many events, still time-driven
      repeat (5) cyc(2'b01, 1'b0, 1'b0, 3'd0, 32'd0);
      wait_flag(30, 40, n);
      chk("R4 count limit zero ignores count", 32'(n), 32'(3 * DIV + 2 - 4));
      wr(3'd2, 32'hFFFF_FFFF);

      // R3: zero time limit disables, and pending is dropped
      wr(3'd0, (32'd1 << 8) | 32'd0);
      repeat (3) cyc(2'b01, 1'b0, 1'b0, 3'd0, 32'd0);
      repeat (20) idle();
      chk("R3 disabled direction raises nothing", 32'(rd_data[30]), 32'd0);
      chk("R7 queue flag independent of delay", 32'(rd_data[16]), 32'd1);
      wr(3'd0, 32'd2);
      repeat (20) idle();
      chk("R3 old events dropped on re-enable", 32'(rd_data[30]), 32'd0);
      wr(3'd2, 32'hFFFF_FFFF);

      // R6: event on the fire edge starts the next batch
      wr(3'd1, (32'd2 << 8) | 32'd50);
      repeat (3) cyc('0, 1'b1, 1'b0, 3'd0, 32'd0);
      wr(3'd2, 32'd1 << 28);
      cyc('0, 1'b1, 1'b0, 3'd0, 32'd0);
      idle();
      chk("R6 no flag while new batch below limit", 32'(rd_data[28]), 32'd0);
      idle();
      chk("R6 carried event completes batch", 32'(rd_data[28]), 32'd1);
      wr(3'd2, 32'hFFFF_FFFF);

      // R8: set wins over clear, zero bits untouched
      wr(3'd1, (32'd1 << 8) | 32'd50);
      wr(3'd0, 32'd0);
      cyc(2'b01, 1'b1, 1'b0, 3'd0, 32'd0);
      wr(3'd2, 32'd1 << 28);
      idle();
      chk("R8 set on clear edge stays set", 32'(rd_data[28]), 32'd1);
      chk("R8 queue flag kept", 32'(rd_data[16]), 32'd1);
      wr(3'd2, 32'd1 << 28);
      idle();
      chk("R8 written one clears", 32'(rd_data[28]), 32'd0);
      chk("R8 written zero leaves bit", 32'(rd_data[16]), 32'd1);

      // R9: masking
      chk("R9 irq low with empty mask", 32'(irq), 32'd0);
      wr(3'd3, 32'd1 << 17);
      idle();
      chk("R9 irq low when mask misses", 32'(irq), 32'd0);
      wr(3'd3, 32'd1 << 16);
      idle();
      chk("R9 irq high on enabled bit", 32'(irq), 32'd1);
      peek(3'd3); chk("R11 mask readback", rd_data, 32'd1 << 16);
      peek(3'd2);
      wr(3'd2, 32'd1 << 16);
      idle();
      chk("R9 irq low after clear", 32'(irq), 32'd0);

      // R11: map and field layout
      wr(3'd0, 32'hABCD_1234);
      idle();
      peek(3'd0); chk("R11 rx limits field layout", rd_data, 32'h0000_1234);
      peek(3'd1); chk("R11 tx limits readback", rd_data, 32'h0000_0132);
      peek(3'd7); chk("R11 unmapped reads zero", rd_data, 32'd0);
      peek(3'd2);
      repeat (4) idle();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule